// File: doc/BRIEF.md
# Prescaled One-Shot Down Timer Bank

This block is a bank of identical timer channels. Each channel has a 16-bit down counter and its own power-of-two clock prescaler. Writing a nonzero value to a channel's count register starts that channel. From then on its counter drops by one on every prescaled tick. When the counter reaches zero, the channel stops, sets a sticky done flag and, if its interrupt enable is set, drives its interrupt line. Writing zero stops a running channel without raising the flag. There is no separate start bit: the write of the load value is the start command.

Software reaches the bank through a plain synchronous write port and a combinational read port that share one address. The address is `{channel, register}`, and the register field is the low two bits. Each channel runs a two-state machine. In state IDLE the counter holds its value. In state RUN it decrements on each tick. The transitions are:

- Start: IDLE to RUN, on a nonzero load.
- Reload: RUN to RUN, on a nonzero load. The count restarts from the new value and the prescaler phase is cleared.
- Abort: RUN to IDLE, on a zero load.
- Expire: RUN to IDLE, on the tick that takes the count from 1 to 0.

Top module: `st_timer_bank`

## Requirements
- R1: After reset every register of every channel reads 0 and all interrupt lines are low.
- R2: With prescale setting N (0..7), a nonzero load starts the channel. The first decrement happens 2^N clock edges after the load edge, and each further decrement follows 2^N edges later. The count register reads the current count.
- R3: On the edge where the count goes from 1 to 0, the done flag sets in the same edge. The counter then stays at 0, so a load of v expires exactly v*2^N edges after the load edge.
- R4: A load of 0 stops the channel immediately, and the count reads 0. The done flag is not set.
- R5: A load while running restarts the count from the new value, with a fresh prescaler phase.
- R6: The done flag is sticky. Writing a 1 to status bit 0 clears it, and writing a 0 has no effect. If a clear and an expiry fall on the same edge, the flag ends up set.
- R7: A channel's interrupt line equals its done flag ANDed with its interrupt-enable bit.
- R8: Writes to one channel do not change the count, configuration or flag of any other channel.
- R9: The register map is as follows. Register 0 reads the current count, and writing it loads the count. Register 1 is the configuration: bits [2:0] hold the prescale N and bit 3 holds the interrupt enable; it reads back as written. Register 2 is status, with the done flag at bit 0. Register 3 reads 0. Writing the configuration also clears the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | {channel, register} address for both write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| irq | output | 2 | Per-channel interrupt, done flag AND enable |

## Verification
The hardest case to reach is a clear of the done flag that lands on the very edge where the count expires. The bench reaches it with a prescale of 0 and a load of 1, followed back to back by the status clear write, so that both events share one edge. Other cases depend on exact phase. A configuration write in the middle of a prescale period must restart the tick phase. The bench places that write five cycles into a period of eight and then times the expiry from the configuration edge. The main sweep covers every prescale setting with several load values on both channels, and checks the count at every tick boundary.

// File: rtl/st_pkg.sv
package st_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } chan_state_t;

    localparam logic [1:0] REG_LOAD = 2'd0;
    localparam logic [1:0] REG_CFG  = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
endpackage

// File: rtl/st_prescaler.sv
module st_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic [PS_W-1:0] shift,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] limit;

    assign limit = {DIV_W{1'b1}} >> (DIV_W - int'(shift));
    assign tick  = run && !restart && (phase_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == '0))
        else $error("prescaler phase not cleared on restart"); // R5
endmodule

// File: rtl/st_channel.sv
module st_channel
    import st_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_we,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             cfg_we,
    input  logic [PS_W-1:0]  cfg_shift,
    input  logic             cfg_ie,
    input  logic             clr_we,
    output logic [CNT_W-1:0] count_o,
    output logic [PS_W-1:0]  shift_o,
    output logic             ie_o,
    output logic             flag_o,
    output logic             irq_o
);
    chan_state_t      state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [PS_W-1:0]  shift_q;
    logic             ie_q;
    logic             flag_q;
    logic             tick;
    logic             expire;

    st_prescaler #(.PS_W(PS_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_RUN),
        .restart(ld_we || cfg_we),
        .shift  (shift_q),
        .tick   (tick)
    );

    assign expire = (state_q == ST_RUN) && tick && !ld_we && (count_q == CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ld_we && ld_val != '0) state_d = ST_RUN;
            ST_RUN: begin
                if (ld_we)       state_d = (ld_val != '0) ? ST_RUN : ST_IDLE;
                else if (expire) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            shift_q <= '0;
            ie_q    <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (ld_we)                              count_q <= ld_val;
            else if (state_q == ST_RUN && tick)     count_q <= count_q - 1'b1;
            if (cfg_we) begin
                shift_q <= cfg_shift;
                ie_q    <= cfg_ie;
            end
            flag_q <= expire || (flag_q && !clr_we);
        end
    end

    assign count_o = count_q;
    assign shift_o = shift_q;
    assign ie_o    = ie_q;
    assign flag_o  = flag_q;
    assign irq_o   = flag_q && ie_q;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick && !ld_we) |=> (count_q == $past(count_q) - 1'b1))
        else $error("count did not step by one"); // R2
    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (count_q != '0))
        else $error("running with zero count"); // R3
    AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !ld_we) |=> $stable(count_q))
        else $error("idle count moved"); // R3
    AST_ZERO_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we && ld_val == '0 && !flag_q) |=> !flag_q)
        else $error("zero load raised flag"); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_we) |=> flag_q)
        else $error("flag dropped without clear"); // R6
endmodule

// File: rtl/st_timer_bank.sv
module st_timer_bank
    import st_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int CNT_W = 16,
    parameter int PS_W  = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [((NCH > 1) ? $clog2(NCH) : 1)+1:0] addr,
    input  logic [CNT_W-1:0]                     wdata,
    output logic [CNT_W-1:0]                     rdata,
    output logic [NCH-1:0]                       irq
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [CH_W-1:0]  ch_sel;
    logic [1:0]       reg_sel;
    logic [CNT_W-1:0] count_a [NCH];
    logic [PS_W-1:0]  shift_a [NCH];
    logic [NCH-1:0]   ie_a;
    logic [NCH-1:0]   flag_a;

    assign ch_sel  = addr[CH_W+1:2];
    assign reg_sel = addr[1:0];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = wr_en && (ch_sel == CH_W'(i));

        st_channel #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_we    (hit && reg_sel == REG_LOAD),
            .ld_val   (wdata),
            .cfg_we   (hit && reg_sel == REG_CFG),
            .cfg_shift(wdata[PS_W-1:0]),
            .cfg_ie   (wdata[PS_W]),
            .clr_we   (hit && reg_sel == REG_STAT && wdata[0]),
            .count_o  (count_a[i]),
            .shift_o  (shift_a[i]),
            .ie_o     (ie_a[i]),
            .flag_o   (flag_a[i]),
            .irq_o    (irq[i])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_sel == CH_W'(i)) begin
                unique case (reg_sel)
                    REG_LOAD: rdata = count_a[i];
                    REG_CFG:  rdata = CNT_W'({ie_a[i], shift_a[i]});
                    REG_STAT: rdata = CNT_W'(flag_a[i]);
                    default:  rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: tb/test_st_timer_bank.sv
`timescale 1ns/100ps
module test_st_timer_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  irq;

    int nvec = 0;
    int nfail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    st_timer_bank i_st_timer_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // caller is at a falling edge; write lands on the next rising edge
    task automatic wr(input int ch, input int rg, input int val);
        addr  = 3'((ch << 2) | rg);
        wdata = 16'(val);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int ch, input int rg, output int val);
        addr = 3'((ch << 2) | rg);
        #0.2;
        val = int'(rdata);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // time from the last write edge to the flag; count checked each period
    task automatic time_flag(input int ch, input int v, input int p, input string req);
        int m = 0;
        int f, c;
        forever begin
            rd(ch, 2, f);
            if (f != 0 || m > 5000) break;
            if (m % p == 0) begin
                rd(ch, 0, c);
                check({req, " count"}, c, v - m / p);
            end
            @(negedge clk);
            m++;
        end
        check({req, " expiry cycles"}, m, v * p);
        rd(ch, 0, c);
        check("R3 count held at zero", c, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        int v0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(a >> 2, a & 3, v0);
            check("R1 reset read", v0, 0);
        end
        check("R1 reset irq", int'(irq), 0);
        @(negedge clk);

        // R2/R3 sweep: both channels, every prescale, several loads
        for (int ch = 0; ch < 2; ch++) begin
            for (int n = 0; n < 8; n++) begin
                for (int v = 1; v <= 3; v++) begin
                    wr(ch, 1, n);
                    wr(ch, 0, v);
                    time_flag(ch, v, 1 << n, "R2");
                    @(negedge clk);
                    wr(ch, 2, 1);
                    rd(ch, 2, v0);
                    check("R6 clear by one", v0, 0);
                    @(negedge clk);
                end
            end
        end

        // R9 register map readback
        wr(0, 1, 16'h000D);
        rd(0, 1, v0);
        check("R9 cfg readback", v0, 13);
        rd(0, 3, v0);
        check("R9 reserved reads zero", v0, 0);
        @(negedge clk);

        // R5 reload while running
        wr(0, 1, 2);
        wr(0, 0, 10);
        idle(6);
        rd(0, 0, v0);
        check("R5 count before reload", v0, 9);
        @(negedge clk);
        wr(0, 0, 3);
        time_flag(0, 3, 4, "R5");
        @(negedge clk);
        wr(0, 2, 1);

        // R9 configuration write clears prescaler phase
        wr(0, 1, 3);
        wr(0, 0, 4);
        idle(5);
        wr(0, 1, 3);
        time_flag(0, 4, 8, "R9");
        @(negedge clk);
        wr(0, 2, 1);

        // R4 zero load stops and stays quiet
        wr(0, 1, 1);
        wr(0, 0, 5);
        idle(3);
        wr(0, 0, 0);
        rd(0, 0, v0);
        check("R4 count after zero load", v0, 0);
        @(negedge clk);
        idle(40);
        rd(0, 0, v0);
        check("R4 count stays zero", v0, 0);
        rd(0, 2, v0);
        check("R4 no flag", v0, 0);
        @(negedge clk);

        // R6 set wins over a same-edge clear
        wr(0, 1, 16'h0008);
        wr(0, 0, 1);
        wr(0, 2, 1);
        rd(0, 2, v0);
        check("R6 set wins over clear", v0, 1);
        check("R7 irq with enable", int'(irq[0]), 1);
        @(negedge clk);
        wr(0, 2, 1);

        // R7 enable gating, R6 write of zero ignored
        wr(0, 1, 0);
        wr(0, 0, 2);
        idle(3);
        rd(0, 2, v0);
        check("R7 flag set", v0, 1);
        check("R7 irq masked", int'(irq[0]), 0);
        @(negedge clk);
        wr(0, 1, 16'h0008);
        check("R7 irq unmasked", int'(irq[0]), 1);
        wr(0, 2, 0);
        rd(0, 2, v0);
        check("R6 write zero ignored", v0, 1);
        @(negedge clk);
        wr(0, 2, 1);
        check("R7 irq after clear", int'(irq[0]), 0);

        // R8 channel independence
        wr(1, 1, 16'h000F);
        wr(1, 0, 50);
        wr(0, 1, 16'h0005);
        wr(0, 0, 7);
        wr(0, 2, 1);
        wr(0, 0, 0);
        rd(1, 0, v0);
        check("R8 other count untouched", v0, 50);
        rd(1, 1, v0);
        check("R8 other cfg untouched", v0, 15);
        rd(1, 2, v0);
        check("R8 other flag untouched", v0, 0);
        check("R8 irq untouched", int'(irq), 0);
        @(negedge clk);
        wr(1, 0, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule